// File: doc/BRIEF.md
# Dual Reload Down-Counter Timer

This block holds two independent 32-bit timers that count down, one step per cycle in which the `tick` input is high. Each timer has a reload register and a live count register. Both timers share a single control word, which holds a run bit and an auto-reload bit for each timer. When a running timer reaches zero on a tick, it expires. Expiry produces a one-clock pulse on that timer's own interrupt line. If auto-reload is set, the timer then restarts from its reload value. If not, the timer parks at zero and clears its own run bit. A reload value of N-1 therefore gives one expiry every N ticks.

Software uses a simple 32-bit register bus with a write strobe, a byte address and write data. Read data is a combinational function of the address.

Each timer is one instance of a two-state machine:
- `CH_IDLE`: the count is frozen and no interrupt can occur.
- `CH_COUNT`: the count decrements on each tick.

The machine has three transitions:
- *arm*: a control write with the run bit set moves `CH_IDLE` to `CH_COUNT`.
- *disarm*: a control write with the run bit clear moves `CH_COUNT` to `CH_IDLE`.
- *one-shot stop*: an expiry with auto-reload clear moves `CH_COUNT` to `CH_IDLE`.

A control write in the same cycle as an expiry takes precedence over the one-shot stop.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset, every register reads zero, both timers are in `CH_IDLE`, and both `irq` bits are low.
- R2: The control word is at offset 0x00. Bit 0 is timer 0 run, bit 1 is timer 0 auto-reload, bit 2 is timer 1 run and bit 3 is timer 1 auto-reload. The written bits read back, and bits 31:4 read zero.
- R3: Timer 0 has its reload register at offset 0x10 and its count register at 0x14. Timer 1 has its reload register at 0x18 and its count register at 0x1C. Written values read back, and offsets 0x04, 0x08 and 0x0C read zero.
- R4: A running timer with a non-zero count decrements by one on each cycle with `tick` high. It does not change on cycles with `tick` low.
- R5: A running timer expires on a tick in which its count is zero. Its `irq` bit is high for exactly the cycle after that clock edge.
- R6: With auto-reload set, an expiry loads the reload value. A reload value of N-1 gives one expiry every N ticks.
- R7: With auto-reload clear, a count of V produces exactly one expiry, at tick V+1. After that the count stays zero, the run bit reads zero and no further `irq` occurs.
- R8: A timer in `CH_IDLE` holds its count on ticks and never raises its `irq`.
- R9: A bus write to a count register sets the count in that cycle. It overrides a decrement or a reload due in the same cycle.
- R10: Each timer drives only its own `irq` bit, with timer 0 on bit 0 and timer 1 on bit 1. The other timer's activity has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable; one step per high cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| irq | output | 2 | Per-timer expiry pulse, bit i for timer i |

## Verification
The countdown is run with several shapes of stimulus:
- Periodic runs whose start count differs from the reload value. These separate the first interval (start plus one) from the steady interval (reload plus one).
- A reload of zero, which must give an expiry on every tick.
- One-shot runs stopped before and after zero. These show whether the timer parks and drops its run bit or keeps firing.

In every run the idle timer's interrupt is watched, to catch crosstalk between the two timers. Directed cases then cover these points:
- a frozen count with the timer disabled;
- a frozen count with `tick` low;
- a count write that collides with a decrement;
- a count write that collides with a reload, which shows whether the write or the counter logic wins.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
    localparam int NUM_TIMERS  = 2;
    localparam int CTRL_OFS    = 'h00;
    localparam int RELOAD_BASE = 'h10;
    localparam int COUNT_BASE  = 'h14;
    localparam int TMR_STRIDE  = 8;

    typedef enum logic {
        CH_IDLE  = 1'b0,
        CH_COUNT = 1'b1
    } ch_state_t;
endpackage

// File: rtl/dtmr_channel.sv
module dtmr_channel #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ctl_wr,
    input  logic              ctl_run,
    input  logic              ctl_auto,
    input  logic              rld_wr,
    input  logic              cnt_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              run,
    output logic              auto_rl,
    output logic [DATA_W-1:0] reload_val,
    output logic [DATA_W-1:0] count_val,
    output logic              irq
);
    import dtmr_pkg::*;

    ch_state_t         state_q, state_d;
    logic [DATA_W-1:0] count_q, count_d;
    logic [DATA_W-1:0] reload_q;
    logic              auto_q;
    logic              irq_q;
    logic              expire;

    assign expire = (state_q == CH_COUNT) && tick && (count_q == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (ctl_wr && ctl_run) state_d = CH_COUNT;
            end
            CH_COUNT: begin
                if (ctl_wr)                  state_d = ctl_run ? CH_COUNT : CH_IDLE;
                else if (expire && !auto_q)  state_d = CH_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // count datapath
    always_comb begin
        count_d = count_q;
        if (cnt_wr)
            count_d = wdata;
        else if (expire && auto_q)
            count_d = reload_q;
        else if ((state_q == CH_COUNT) && tick && (count_q != '0))
            count_d = count_q - DATA_W'(1);
    end

    // outputs and configuration storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            reload_q <= '0;
            auto_q   <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            count_q <= count_d;
            irq_q   <= expire;
            if (rld_wr) reload_q <= wdata;
            if (ctl_wr) auto_q   <= ctl_auto;
        end
    end

    assign run        = (state_q == CH_COUNT);
    assign auto_rl    = auto_q;
    assign reload_val = reload_q;
    assign count_val  = count_q;
    assign irq        = irq_q;
endmodule

// File: rtl/dtmr_regfile.sv
module dtmr_regfile #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int NUM    = 2
) (
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [NUM-1:0]              run_vec,
    input  logic [NUM-1:0]              auto_vec,
    input  logic [NUM-1:0][DATA_W-1:0]  reload_vec,
    input  logic [NUM-1:0][DATA_W-1:0]  count_vec,
    output logic                        ctl_wr,
    output logic [NUM-1:0]              rld_wr,
    output logic [NUM-1:0]              cnt_wr,
    output logic [DATA_W-1:0]           bus_rdata
);
    import dtmr_pkg::*;

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

    logic [NUM-1:0] rld_hit, cnt_hit;

    for (genvar i = 0; i < NUM; i++) begin : g_dec
        localparam logic [ADDR_W-1:0] RLD_A = ADDR_W'(RELOAD_BASE + TMR_STRIDE * i);
        localparam logic [ADDR_W-1:0] CNT_A = ADDR_W'(COUNT_BASE + TMR_STRIDE * i);
        assign rld_hit[i] = (bus_addr == RLD_A);
        assign cnt_hit[i] = (bus_addr == CNT_A);
        assign rld_wr[i]  = bus_wr && rld_hit[i];
        assign cnt_wr[i]  = bus_wr && cnt_hit[i];
    end

    assign ctl_wr = bus_wr && (bus_addr == CTRL_A);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_A) begin
            for (int i = 0; i < NUM; i++) begin
                bus_rdata[2*i]   = run_vec[i];
                bus_rdata[2*i+1] = auto_vec[i];
            end
        end
        for (int i = 0; i < NUM; i++) begin
            if (rld_hit[i]) bus_rdata = reload_vec[i];
            if (cnt_hit[i]) bus_rdata = count_vec[i];
        end
    end
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [1:0]        irq
);
    localparam int NUM = dtmr_pkg::NUM_TIMERS;

    logic                       ctl_wr;
    logic [NUM-1:0]             rld_wr, cnt_wr;
    logic [NUM-1:0]             run_vec, auto_vec;
    logic [NUM-1:0][DATA_W-1:0] reload_vec, count_vec;

    dtmr_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM(NUM)) u_regs (
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .run_vec    (run_vec),
        .auto_vec   (auto_vec),
        .reload_vec (reload_vec),
        .count_vec  (count_vec),
        .ctl_wr     (ctl_wr),
        .rld_wr     (rld_wr),
        .cnt_wr     (cnt_wr),
        .bus_rdata  (bus_rdata)
    );

    for (genvar i = 0; i < NUM; i++) begin : g_tmr
        dtmr_channel #(.DATA_W(DATA_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick),
            .ctl_wr     (ctl_wr),
            .ctl_run    (bus_wdata[2*i]),
            .ctl_auto   (bus_wdata[2*i+1]),
            .rld_wr     (rld_wr[i]),
            .cnt_wr     (cnt_wr[i]),
            .wdata      (bus_wdata),
            .run        (run_vec[i]),
            .auto_rl    (auto_vec[i]),
            .reload_val (reload_vec[i]),
            .count_val  (count_vec[i]),
            .irq        (irq[i])
        );
    end
endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker #(
    parameter int DATA_W = 32,
    parameter int NUM    = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       tick,
    input logic                       bus_wr,
    input logic [NUM-1:0]             irq,
    input logic [NUM-1:0]             run_vec,
    input logic [NUM-1:0]             auto_vec,
    input logic [NUM-1:0][DATA_W-1:0] count_vec
);
    for (genvar i = 0; i < NUM; i++) begin : g_chk
        assert_irq_needs_zero_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> ($past(tick) && ($past(count_vec[i]) == '0)));

        assert_idle_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> $past(run_vec[i]));

        assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_vec[i] && !bus_wr) |=> $stable(count_vec[i]));

        assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (run_vec[i] && tick && !bus_wr && (count_vec[i] != '0))
            |=> (count_vec[i] == $past(count_vec[i]) - DATA_W'(1)));

        assert_no_tick_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!tick && !bus_wr) |=> $stable(count_vec[i]));

        assert_oneshot_parks_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (run_vec[i] && tick && !bus_wr && !auto_vec[i] && (count_vec[i] == '0))
            |=> (!run_vec[i] && (count_vec[i] == '0)));
    end
endmodule

bind dual_reload_timer dtmr_checker #(.DATA_W(DATA_W), .NUM(NUM)) u_dtmr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_wr    (bus_wr),
    .irq       (irq),
    .run_vec   (run_vec),
    .auto_vec  (auto_vec),
    .count_vec (count_vec)
);

// File: tb/test_dual_reload_timer.sv
module test_dual_reload_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    dual_reload_timer i_dual_reload_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [31:0] tmr;
        logic [31:0] start;
        logic [31:0] rld;
        logic [31:0] auto_en;
        logic [31:0] ticks;
        logic [31:0] exp_irqs;
        logic [31:0] exp_cnt;
        logic [31:0] exp_run;
    } vec_t;

    // tmr, start, reload, auto, ticks, expected irqs, expected count, expected run
    localparam vec_t VECS [6] = '{
        '{32'd0, 32'd3, 32'd3, 32'd1, 32'd8,  32'd2, 32'd3, 32'd1},
        '{32'd1, 32'd4, 32'd9, 32'd1, 32'd10, 32'd1, 32'd4, 32'd1},
        '{32'd0, 32'd5, 32'd0, 32'd0, 32'd10, 32'd1, 32'd0, 32'd0},
        '{32'd1, 32'd0, 32'd0, 32'd1, 32'd5,  32'd5, 32'd0, 32'd1},
        '{32'd0, 32'd2, 32'd7, 32'd0, 32'd2,  32'd0, 32'd0, 32'd1},
        '{32'd1, 32'd1, 32'd2, 32'd1, 32'd9,  32'd3, 32'd1, 32'd1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // all bus tasks start and end just after a falling edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic run_ticks(input int n, output int c0, output int c1);
        c0 = 0; c1 = 0;
        for (int k = 0; k < n; k++) begin
            tick = 1'b1;
            @(posedge clk); @(negedge clk);
            c0 += int'(irq[0]);
            c1 += int'(irq[1]);
        end
        tick = 1'b0;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int c0, c1, own, other;
        logic [4:0] rld_a, cnt_a;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 32; a += 4) begin
            rd(5'(a), d);
            check("R1 reset read", d, 32'h0);
        end
        check("R1 irq at reset", {30'h0, irq}, 32'h0);

        // R2 control layout
        wr(5'h00, 32'hFFFF_FFFA);
        rd(5'h00, d);
        check("R2 ctrl auto bits", d, 32'h0000_000A);
        wr(5'h00, 32'h0000_0005);
        rd(5'h00, d);
        check("R2 ctrl run bits", d, 32'h0000_0005);
        wr(5'h00, 32'h0);

        // R3 offsets and unused addresses
        wr(5'h10, 32'h1111_0010); wr(5'h14, 32'h2222_0014);
        wr(5'h18, 32'h3333_0018); wr(5'h1C, 32'h4444_001C);
        rd(5'h10, d); check("R3 reload0", d, 32'h1111_0010);
        rd(5'h14, d); check("R3 count0",  d, 32'h2222_0014);
        rd(5'h18, d); check("R3 reload1", d, 32'h3333_0018);
        rd(5'h1C, d); check("R3 count1",  d, 32'h4444_001C);
        rd(5'h04, d); check("R3 unused 0x04", d, 32'h0);
        rd(5'h08, d); check("R3 unused 0x08", d, 32'h0);
        rd(5'h0C, d); check("R3 unused 0x0C", d, 32'h0);

        // R8 idle timer holds and stays quiet
        wr(5'h14, 32'd20);
        run_ticks(5, c0, c1);
        rd(5'h14, d); check("R8 idle count held", d, 32'd20);
        check("R8 idle irq count", 32'(c0 + c1), 32'h0);

        // R4 no tick, no change
        wr(5'h00, 32'h1);
        repeat (5) @(negedge clk);
        rd(5'h14, d); check("R4 hold without tick", d, 32'd20);
        run_ticks(3, c0, c1);
        rd(5'h14, d); check("R4 three ticks", d, 32'd17);

        // R9 count write vs decrement
        tick = 1'b1;
        wr(5'h14, 32'd50);
        tick = 1'b0;
        rd(5'h14, d); check("R9 write beats decrement", d, 32'd50);

        // R9 count write vs reload on expiry
        wr(5'h00, 32'h0);
        wr(5'h10, 32'd7);
        wr(5'h14, 32'd0);
        wr(5'h00, 32'h3);
        tick = 1'b1;
        wr(5'h14, 32'd40);
        c0 = int'(irq[0]);
        tick = 1'b0;
        rd(5'h14, d); check("R9 write beats reload", d, 32'd40);
        check("R5 expiry still signalled", 32'(c0), 32'd1);

        // vector table: R5 R6 R7 R10
        for (int v = 0; v < 6; v++) begin
            wr(5'h00, 32'h0);
            rld_a = 5'(16 + 8 * VECS[v].tmr);
            cnt_a = 5'(20 + 8 * VECS[v].tmr);
            wr(rld_a, VECS[v].rld);
            wr(cnt_a, VECS[v].start);
            wr(5'h00, ({31'h0, VECS[v].auto_en[0]} << 1 | 32'h1) << (2 * VECS[v].tmr));
            run_ticks(int'(VECS[v].ticks), c0, c1);
            own   = (VECS[v].tmr == 0) ? c0 : c1;
            other = (VECS[v].tmr == 0) ? c1 : c0;
            check($sformatf("R5 R6 R7 vec%0d irq count", v), 32'(own), VECS[v].exp_irqs);
            check($sformatf("R10 vec%0d other irq", v), 32'(other), 32'h0);
            rd(cnt_a, d);
            check($sformatf("R6 R7 vec%0d final count", v), d, VECS[v].exp_cnt);
            rd(5'h00, d);
            check($sformatf("R7 vec%0d run bit", v), (d >> (2 * VECS[v].tmr)) & 32'h1, VECS[v].exp_run);
            if (VECS[v].exp_run == 0) begin
                run_ticks(4, c0, c1);
                check($sformatf("R7 vec%0d quiet after stop", v), 32'(c0 + c1), 32'h0);
            end
        end

        // R5 pulse timing: count 2, expiry on third tick, irq one cycle wide
        wr(5'h00, 32'h0);
        wr(5'h14, 32'd2);
        wr(5'h00, 32'h1);
        run_ticks(2, c0, c1);
        check("R5 no irq before zero tick", {30'h0, irq}, 32'h0);
        run_ticks(1, c0, c1);
        check("R5 irq after zero tick", {30'h0, irq}, 32'h1);
        @(posedge clk); @(negedge clk);
        check("R5 irq single cycle", {30'h0, irq}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule